// File: doc/BRIEF.md
# Interrupt Flag Controller for a Four-Phase Controller Core

This block holds the interrupt state of a small 8-bit controller core whose instruction cycle is split into four clock phases. Three event sources are latched into flag bits of one 8-bit control register:

- an external pin, with a selectable active edge;
- a timer wrap pulse;
- a port-change pulse.

Each flag is qualified by its own enable bit, and all of them together by a global enable. Software reads the register and writes all eight bits of it. No flag is ever cleared by hardware.

The core supplies two strobes that mark the first and last phase of each instruction cycle. Pending work is sampled on the first-phase strobe. The vector request then arrives a fixed number of instruction cycles later, after one dummy cycle. It is not affected by the instruction that is running. When the vector is taken, the block loads the vector address onto its program-counter output and clears the global enable. While the core sleeps, any enabled flag raises a wake request, whatever the state of the global enable. After the core leaves sleep, the global enable alone decides whether a vector follows.

Control register bit map:

| Bit | Meaning |
|-----|---------|
| 7 | global enable |
| 6 | plain storage |
| 5 | timer enable |
| 4 | pin enable |
| 3 | port-change enable |
| 2 | timer flag |
| 1 | pin flag |
| 0 | port-change flag |

Top module: `intc_flagctl`

## Requirements
- R1: The pin passes through a two-stage synchronizer. A rising edge counts when `xedge_rise`=1 and a falling edge when `xedge_rise`=0; the opposite edge is ignored. A detected edge sets bit 1 on the first clock at or after detection where `q1_stb` or `q4_stb` is high. An edge seen outside those strobes is held until such a clock.
- R2: A high `tmr_wrap` on a clock sets bit 2 on that clock.
- R3: A high `port_chg` on a clock sets bit 0 on that clock.
- R4: Flag bits 2:0 stay set until a register write puts 0 into them.
- R5: `ctl_we` loads all eight bits from `ctl_wdata`, including the storage bit 6. A hardware flag set on the same clock wins over the written value.
- R6: On a `q1_stb` clock, a sample is taken if no vector is in progress, `sleep_mode`=0, bit 7=1, and some flag in bit 2, 1 or 0 has its enable in bit 5, 4 or 3 (respectively) set. If the sample is pending, `vec_take` pulses on the second following `q1_stb` clock. `dummy_cyc` is high for the whole instruction cycle that ends with that clock. `vec_pc` equals the vector address 0004h while `vec_take` is high and is 0 otherwise.
- R7: The clock that takes a vector clears bit 7, which wins over a write on that clock. Flag bits are left as they are.
- R8: `wake` is high exactly when `sleep_mode`=1 and some flag has its enable set, with no regard to bit 7.
- R9: After `sleep_mode` returns to 0, a pending enabled flag leads to a vector only if bit 7=1.
- R10: With bit 7=0, or with the matching enable clear, a set flag never produces `vec_take`.
- R11: Reset clears the register and the latency state, so `vec_take`, `dummy_cyc` and `wake` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | phase clock |
| rst_n | input | 1 | asynchronous active-low reset |
| q1_stb | input | 1 | first-phase strobe of each instruction cycle |
| q4_stb | input | 1 | last-phase strobe of each instruction cycle |
| xpin | input | 1 | external interrupt pin, asynchronous |
| xedge_rise | input | 1 | 1 selects the rising edge, 0 the falling edge |
| tmr_wrap | input | 1 | timer wrap pulse |
| port_chg | input | 1 | port-change pulse |
| ctl_we | input | 1 | control register write strobe |
| ctl_wdata | input | 8 | control register write data |
| ctl_q | output | 8 | control register contents |
| sleep_mode | input | 1 | core is sleeping |
| wake | output | 1 | wake request |
| dummy_cyc | output | 1 | dummy instruction cycle before the vector |
| vec_take | output | 1 | vector taken this clock; push the return address |
| vec_pc | output | PC_W | program counter load value |

## Verification
A lost or stuck flag shows on `ctl_q` on the clock after the event, or on the strobe clock that follows a pin edge. A flag that was never cleared also shows as `wake` during sleep and as a vector roughly two instruction cycles later. A wrong latency state shows as `vec_take` or `dummy_cyc` moving by whole instruction cycles. It can also show as bit 7 staying set after a vector, which can be seen on the clock after the vector. A wrong enable gating shows as `wake` or `vec_take` appearing or missing within two instruction cycles of the flag being set.

// File: rtl/intc_flagctl.sv
module intc_flagctl #(
  parameter int PC_W = 13,
  parameter logic [PC_W-1:0] VEC_PC = 'h4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            q1_stb,
  input  logic            q4_stb,
  input  logic            xpin,
  input  logic            xedge_rise,
  input  logic            tmr_wrap,
  input  logic            port_chg,
  input  logic            ctl_we,
  input  logic [7:0]      ctl_wdata,
  output logic [7:0]      ctl_q,
  input  logic            sleep_mode,
  output logic            wake,
  output logic            dummy_cyc,
  output logic            vec_take,
  output logic [PC_W-1:0] vec_pc
);
  localparam int B_GIE = 7, B_TEN = 5, B_XEN = 4, B_PEN = 3;
  localparam int B_TFL = 2, B_XFL = 1, B_PFL = 0;
  localparam logic [1:0] ST_IDLE = 2'd0, ST_FIN = 2'd1, ST_DUMMY = 2'd2;

  logic [2:0] sy;
  logic       held;
  logic [7:0] ctl, ctl_n;
  logic [1:0] st;

  wire cur    = sy[1];
  wire prev   = sy[2];
  wire xedge  = xedge_rise ? (cur & ~prev) : (~cur & prev);
  wire win    = q1_stb | q4_stb;
  wire [2:0] hits = {ctl[B_TFL] & ctl[B_TEN], ctl[B_XFL] & ctl[B_XEN], ctl[B_PFL] & ctl[B_PEN]};
  wire pend   = ctl[B_GIE] & |hits;

  assign ctl_q     = ctl;
  assign wake      = sleep_mode & |hits;
  assign dummy_cyc = (st == ST_DUMMY);
  assign vec_take  = q1_stb & dummy_cyc;
  assign vec_pc    = vec_take ? VEC_PC : '0;

  always_comb begin
    ctl_n = ctl_we ? ctl_wdata : ctl;
    if (vec_take)           ctl_n[B_GIE] = 1'b0;
    if (tmr_wrap)           ctl_n[B_TFL] = 1'b1;
    if (port_chg)           ctl_n[B_PFL] = 1'b1;
    if (win & (xedge | held)) ctl_n[B_XFL] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy   <= '0;
      held <= 1'b0;
      ctl  <= '0;
      st   <= ST_IDLE;
    end else begin
      sy   <= {sy[1:0], xpin};
      held <= win ? 1'b0 : (held | xedge);
      ctl  <= ctl_n;
      if (q1_stb) begin
        unique case (st)
          ST_IDLE:  if (pend && !sleep_mode) st <= ST_FIN;
          ST_FIN:   st <= ST_DUMMY;
          default:  st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/intc_flagctl_chk.sv
module intc_flagctl_chk #(
  parameter int PC_W = 13,
  parameter logic [PC_W-1:0] VEC_PC = 'h4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            q1_stb,
  input logic            tmr_wrap,
  input logic            port_chg,
  input logic            ctl_we,
  input logic [7:0]      ctl_q,
  input logic            sleep_mode,
  input logic            wake,
  input logic            dummy_cyc,
  input logic            vec_take,
  input logic [PC_W-1:0] vec_pc
);
  a_r2_timer_sets: assert property (@(posedge clk) disable iff (!rst_n) tmr_wrap |=> ctl_q[2]);
  a_r3_port_sets:  assert property (@(posedge clk) disable iff (!rst_n) port_chg |=> ctl_q[0]);
  a_r4_pin_sticky: assert property (@(posedge clk) disable iff (!rst_n) (ctl_q[1] && !ctl_we) |=> ctl_q[1]);
  a_r4_tmr_sticky: assert property (@(posedge clk) disable iff (!rst_n) (ctl_q[2] && !ctl_we) |=> ctl_q[2]);
  a_r6_vec_on_q1:  assert property (@(posedge clk) disable iff (!rst_n) vec_take |-> (q1_stb && dummy_cyc && vec_pc == VEC_PC));
  a_r6_dummy_start: assert property (@(posedge clk) disable iff (!rst_n) $rose(dummy_cyc) |-> $past(q1_stb));
  a_r7_gie_cleared: assert property (@(posedge clk) disable iff (!rst_n) vec_take |=> !ctl_q[7]);
  a_r8_wake_sleep: assert property (@(posedge clk) disable iff (!rst_n) wake |-> sleep_mode);
endmodule

bind intc_flagctl intc_flagctl_chk #(.PC_W(PC_W), .VEC_PC(VEC_PC)) chk_i (
  .clk(clk), .rst_n(rst_n), .q1_stb(q1_stb), .tmr_wrap(tmr_wrap), .port_chg(port_chg),
  .ctl_we(ctl_we), .ctl_q(ctl_q), .sleep_mode(sleep_mode), .wake(wake),
  .dummy_cyc(dummy_cyc), .vec_take(vec_take), .vec_pc(vec_pc)
);

// File: tb/intc_flagctl_tb.sv
module intc_flagctl_tb_top;
  localparam int PC_W = 13;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, q1_stb, q4_stb, xpin, xedge_rise, tmr_wrap, port_chg, ctl_we, sleep_mode;
  logic [7:0] ctl_wdata, ctl_q;
  logic wake, dummy_cyc, vec_take;
  logic [PC_W-1:0] vec_pc;

  intc_flagctl #(.PC_W(PC_W)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  logic s_rst_n = 1'b0, s_pin = 1'b0, s_rise = 1'b1, s_tmr = 1'b0, s_chg = 1'b0, s_we = 1'b0, s_sleep = 1'b0;
  logic [7:0] s_wd = '0;
  logic [1:0] ph = '0;

  logic [2:0] m_sy;
  logic m_held;
  logic [7:0] m_ctl;
  logic [1:0] m_st;

  function automatic logic m_any(logic [7:0] c);
    return (c[2] & c[5]) | (c[1] & c[4]) | (c[0] & c[3]);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    logic edg, vt;
    logic [7:0] n;
    @(negedge clk);
    rst_n = s_rst_n; xpin = s_pin; xedge_rise = s_rise; tmr_wrap = s_tmr; port_chg = s_chg;
    ctl_we = s_we; ctl_wdata = s_wd; sleep_mode = s_sleep;
    q1_stb = (ph == 2'd0); q4_stb = (ph == 2'd3);
    #1;
    if (rst_n) begin
      vt = (m_st == 2'd2) && q1_stb;
      chk(ctl_q[1] == m_ctl[1], "R1 pin flag", ctl_q[1], m_ctl[1]);
      chk(ctl_q[2] == m_ctl[2], "R2 timer flag", ctl_q[2], m_ctl[2]);
      chk(ctl_q[0] == m_ctl[0], "R3 port flag", ctl_q[0], m_ctl[0]);
      chk(ctl_q[7] == m_ctl[7], "R7 global enable", ctl_q[7], m_ctl[7]);
      chk(ctl_q[6:3] == m_ctl[6:3], "R5 stored bits", ctl_q[6:3], m_ctl[6:3]);
      chk(vec_take == vt, "R6 vec_take", vec_take, vt);
      chk(dummy_cyc == (m_st == 2'd2), "R6 dummy_cyc", dummy_cyc, m_st == 2'd2);
      chk(vec_pc == (vt ? 13'h4 : 13'h0), "R6 vec_pc", vec_pc, vt ? 13'h4 : 13'h0);
      chk(wake == (sleep_mode & m_any(m_ctl)), "R8 wake", wake, sleep_mode & m_any(m_ctl));
    end
    @(posedge clk);
    if (!rst_n) begin
      m_sy = '0; m_held = 1'b0; m_ctl = '0; m_st = '0;
    end else begin
      edg = xedge_rise ? (m_sy[1] & ~m_sy[2]) : (~m_sy[1] & m_sy[2]);
      vt = (m_st == 2'd2) && q1_stb;
      n = ctl_we ? ctl_wdata : m_ctl;
      if (vt) n[7] = 1'b0;
      if (tmr_wrap) n[2] = 1'b1;
      if (port_chg) n[0] = 1'b1;
      if ((q1_stb | q4_stb) & (edg | m_held)) n[1] = 1'b1;
      m_held = (q1_stb | q4_stb) ? 1'b0 : (m_held | edg);
      if (q1_stb) begin
        if (m_st == 2'd0) begin
          if (m_ctl[7] && m_any(m_ctl) && !sleep_mode) m_st = 2'd1;
        end else if (m_st == 2'd1) m_st = 2'd2;
        else m_st = 2'd0;
      end
      m_ctl = n;
      m_sy = {m_sy[1:0], xpin};
    end
    ph = ph + 2'd1;
    s_we = 1'b0; s_tmr = 1'b0; s_chg = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    s_we = 1'b1; s_wd = d; step();
  endtask

  task automatic run(input int k);
    for (int i = 0; i < k; i++) step();
  endtask

  bit done = 1'b0;
  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int nvec;
    void'($urandom(32'h1d5e));
    m_sy = '0; m_held = 0; m_ctl = '0; m_st = '0;
    run(3);
    chk(ctl_q == 8'h00, "R11 reset register", ctl_q, 0);
    chk(!vec_take && !dummy_cyc && !wake, "R11 reset outputs", {vec_take, dummy_cyc, wake}, 0);
    s_rst_n = 1'b1;
    run(4);
    // R1: falling edge selected, rising ignored
    s_rise = 1'b0; s_pin = 1'b1; run(10);
    chk(ctl_q[1] == 1'b0, "R1 rising edge ignored", ctl_q[1], 0);
    s_pin = 1'b0; run(10);
    chk(ctl_q[1] == 1'b1, "R1 falling edge sets flag", ctl_q[1], 1);
    // R10: enabled flag but global enable clear
    wr(8'h12); nvec = 0;
    for (int i = 0; i < 16; i++) begin step(); nvec += vec_take; end
    chk(nvec == 0, "R10 no vector with global enable clear", nvec, 0);
    // R10: global enable set, matching enable clear
    wr(8'hA2); nvec = 0;
    for (int i = 0; i < 16; i++) begin step(); nvec += vec_take; end
    chk(nvec == 0, "R10 no vector with source enable clear", nvec, 0);
    // R6/R7: vector taken with global enable
    wr(8'h92); nvec = 0;
    for (int i = 0; i < 16; i++) begin step(); if (vec_take) begin nvec++; chk(vec_pc == 13'h4, "R6 vector address", vec_pc, 4); end end
    chk(nvec == 1, "R6 one vector taken", nvec, 1);
    chk(ctl_q[7] == 1'b0 && ctl_q[1] == 1'b1, "R7 enable cleared, flag kept", ctl_q, 8'h12);
    // R9/R8: sleep wakes with global enable clear, no vector after
    s_sleep = 1'b1; run(2);
    chk(wake == 1'b1, "R8 wake without global enable", wake, 1);
    s_sleep = 1'b0; nvec = 0;
    for (int i = 0; i < 16; i++) begin step(); nvec += vec_take; end
    chk(nvec == 0, "R9 no vector after wake with enable clear", nvec, 0);
    chk(ctl_q[1] == 1'b1, "R4 flag held until written", ctl_q[1], 1);
    // R5: hardware set wins over write
    s_tmr = 1'b1; wr(8'h40); step();
    chk(ctl_q == 8'h44, "R5 set beats write, bit 6 stored", ctl_q, 8'h44);
    wr(8'h00);
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 7) == 0) s_pin = ~s_pin;
      if ($urandom_range(0, 63) == 0) s_rise = ~s_rise;
      s_tmr = ($urandom_range(0, 19) == 0);
      s_chg = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 99) == 0) s_sleep = ~s_sleep;
      if ($urandom_range(0, 11) == 0) begin s_we = 1'b1; s_wd = 8'($urandom); end
      step();
    end
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule